// File: doc/BRIEF.md
# Configurable Message Queue with Fill-Level Interrupts

This block is a message queue of fixed-width words. It serves one direction at a time. In receive direction, a receive path pushes incoming messages and software pops them. In transmit direction, software pushes outgoing messages and the sending logic pops each one once it has gone out. A 16-bit control word sets the following:

- whether the queue is on;
- how many slots it uses at run time (0, 4, 8 or 16);
- whether interrupts fire per message or on a condition;
- the fill fraction, in eighths, that raises the receive request;
- separate enables for the receive and transmit requests.

In condition mode, the receive request fires once, on the push that brings the stored count up to the chosen fraction of the active depth. The transmit request fires on the pop that drains the queue. In per-message mode, every accepted push (receive) or pop (transmit) raises a request. Requests are single-cycle pulses. A push that finds no room is discarded and latches a sticky overflow flag, which stays set until a clear strobe.

Top module: `msg_fifo_irq`

## Requirements
- R1: After reset the control word reads 0x0000, `empty_o` and `full_o` are both 1, `count_o` is 0, and `rx_irq_o`, `tx_irq_o` and `ovf_o` are 0.
- R2: The control layout is as follows. Bit 0 is the queue enable, bit 1 the receive request enable, bit 2 the transmit request enable, bits 10:8 the depth code, bit 12 the per-message mode, and bits 15:13 the fill level. Bits 11 and 7:3 always read 0. A depth code of 100 to 111 is stored and read back as 000, so writing 0xFFFF reads back 0xF007.
- R3: Depth code 001 gives 4 slots, 010 gives 8 and 011 gives 16. `full_o` rises exactly when `count_o` reaches that number.
- R4: With the enable bit at 0 or the depth code at 000, `empty_o` and `full_o` are both 1, and every push is discarded.
- R5: Pops return words in push order. `pop_data_o` shows the oldest word while the queue is not empty. A pop on an empty queue changes nothing.
- R6: A push that is not accepted (queue full or off) leaves the contents untouched and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is pulsed.
- R7: With `dir_tx_i`=0 and bit 12 at 0, `rx_irq_o` pulses for one cycle in the cycle after the accepted push that makes the count equal to max(1, ceil(depth*(level+1)/8)).
- R8: With `dir_tx_i`=0 and bit 12 at 1, `rx_irq_o` pulses for one cycle after every accepted push.
- R9: With `dir_tx_i`=1 and bit 12 at 0, `tx_irq_o` pulses for one cycle after the accepted pop that leaves the queue empty.
- R10: With `dir_tx_i`=1 and bit 12 at 1, `tx_irq_o` pulses for one cycle after every accepted pop.
- R11: A request pulse needs all three of the following: its own enable bit, the queue enable, and the matching direction. Receive requests never occur in transmit direction, and transmit requests never occur in receive direction.
- R12: A control write that clears the enable, or that changes the depth code, empties the queue (`count_o` becomes 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write value |
| reg_rdata_o | output | 16 | Control word read value |
| dir_tx_i | input | 1 | 0 = receive direction, 1 = transmit direction |
| push_i | input | 1 | Push strobe |
| push_data_i | input | DATA_W | Word to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | DATA_W | Oldest stored word |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | No stored word |
| count_o | output | CNT_W | Stored word count |
| rx_irq_o | output | 1 | Receive request pulse |
| tx_irq_o | output | 1 | Transmit request pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Overflow clear strobe |

## Verification
A wrong count or pointer shows up at the ports in several ways. `count_o` and `full_o` are wrong on the very next cycle. `pop_data_o` returns out-of-order words within one pop. The threshold request fires on the wrong push, because the pulse comes from the post-push count. A missed flush shows as a nonzero `count_o` right after the control write. A bad wrap at a reduced depth surfaces once the queue has cycled past its last slot.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  typedef struct packed {
    logic [2:0] lvl;
    logic       per_msg;
    logic [2:0] dcode;
    logic       txie;
    logic       rxie;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
  import msgq_pkg::*;
#(
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] depth_o,
  output logic [CNT_W-1:0] thr_o,
  output logic             flush_o
);
  localparam int D_Q = MAX_DEPTH / 4;
  localparam int D_H = MAX_DEPTH / 2;

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d.lvl     = wdata_i[15:13];
    ctrl_d.per_msg = wdata_i[12];
    ctrl_d.dcode   = wdata_i[10] ? 3'b000 : wdata_i[10:8];  // prohibited codes -> 0
    ctrl_d.txie    = wdata_i[2];
    ctrl_d.rxie    = wdata_i[1];
    ctrl_d.en      = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_d;
  end

  assign flush_o = we_i && (!ctrl_d.en || (ctrl_d.dcode != ctrl_q.dcode));
  assign ctrl_o  = ctrl_q;
  assign rdata_o = {ctrl_q.lvl, ctrl_q.per_msg, 1'b0, ctrl_q.dcode, 5'b0,
                    ctrl_q.txie, ctrl_q.rxie, ctrl_q.en};

  int unsigned dep, thr;
  always_comb begin
    case (ctrl_q.dcode)
      3'b001:  dep = D_Q;
      3'b010:  dep = D_H;
      3'b011:  dep = MAX_DEPTH;
      default: dep = 0;
    endcase
    if (!ctrl_q.en) dep = 0;
    thr = (dep * (int'(ctrl_q.lvl) + 1) + 7) / 8;
    if (thr == 0) thr = 1;
  end

  assign depth_o = CNT_W'(dep);
  assign thr_o   = CNT_W'(thr);

  p_thr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o != '0) |-> (thr_o <= depth_o && thr_o != '0));
endmodule

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cnt_next_o,
  output logic              push_acc_o,
  output logic              pop_acc_o,
  output logic              ovf_o
);
  localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [MAX_DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  assign full_o     = (cnt_q == depth_i);
  assign empty_o    = (cnt_q == '0);
  assign push_acc_o = push_i && !full_o && !flush_i;
  assign pop_acc_o  = pop_i && !empty_o && !flush_i;
  assign cnt_next_o = cnt_q + CNT_W'(push_acc_o) - CNT_W'(pop_acc_o);

  function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p, logic [CNT_W-1:0] d);
    return (CNT_W'(p) == d - CNT_W'(1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_acc_o) wr_q <= wrap_inc(wr_q, depth_i);
      if (pop_acc_o)  rd_q <= wrap_inc(rd_q, depth_i);
      cnt_q <= cnt_next_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_acc_o) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovf_q <= 1'b0;
    else if (push_i && !push_acc_o)  ovf_q <= 1'b1;
    else if (ovf_clr_i)              ovf_q <= 1'b0;
  end

  assign pop_data_o = mem_q[rd_q];
  assign count_o    = cnt_q;
  assign ovf_o      = ovf_q;

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth_i);
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  p_drop_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(cnt_q));
  p_off_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == '0) |-> (empty_o && full_o));
endmodule

// File: rtl/msgq_irq.sv
module msgq_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxie_i,
  input  logic             txie_i,
  input  logic             per_msg_i,
  input  logic             dir_tx_i,
  input  logic             push_acc_i,
  input  logic             pop_acc_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);
  logic rx_fire, tx_fire, rx_q, tx_q;

  assign rx_fire = en_i && rxie_i && !dir_tx_i && push_acc_i &&
                   (per_msg_i || cnt_next_i == thr_i);
  assign tx_fire = en_i && txie_i && dir_tx_i && pop_acc_i &&
                   (per_msg_i || cnt_next_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_fire;
      tx_q <= tx_fire;
    end
  end

  assign rx_irq_o = rx_q;
  assign tx_irq_o = tx_q;

  p_irq_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_irq_o, tx_irq_o}));
  p_rx_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(en_i && rxie_i && !dir_tx_i));
  p_rx_after_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(push_acc_i));
  p_tx_after_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $past(pop_acc_i && en_i && txie_i));
endmodule

// File: rtl/msg_fifo_irq.sv
module msg_fifo_irq
  import msgq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 16,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              dir_tx_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] depth, thr, cnt_next;
  logic             flush, push_acc, pop_acc;

  msgq_ctrl #(.MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .depth_o(depth), .thr_o(thr), .flush_o(flush)
  );

  msgq_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) i_store (
    .clk_i, .rst_ni,
    .depth_i(depth), .flush_i(flush),
    .push_i, .push_data_i, .pop_i, .ovf_clr_i,
    .pop_data_o, .full_o, .empty_o, .count_o,
    .cnt_next_o(cnt_next), .push_acc_o(push_acc), .pop_acc_o(pop_acc), .ovf_o
  );

  msgq_irq #(.CNT_W(CNT_W)) i_irq (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .rxie_i(ctrl.rxie), .txie_i(ctrl.txie),
    .per_msg_i(ctrl.per_msg), .dir_tx_i,
    .push_acc_i(push_acc), .pop_acc_i(pop_acc),
    .cnt_next_i(cnt_next), .thr_i(thr),
    .rx_irq_o, .tx_irq_o
  );

  p_flush_empties_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count_o == '0));
endmodule

// File: tb/test_msg_fifo_irq.sv
module test_msg_fifo_irq;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          dir_tx = 1'b0;
  logic          push = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          pop = 1'b0;
  logic [DW-1:0] pop_data;
  logic          full, empty, rx_irq, tx_irq, ovf;
  logic          ovf_clr = 1'b0;
  logic [4:0]    count;

  int checks = 0, failures = 0;
  logic last_rx, last_tx;
  logic [DW-1:0] last_pop;

  always #2.5 clk = ~clk;

  msg_fifo_irq i_msg_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dir_tx_i(dir_tx),
    .push_i(push), .push_data_i(push_data),
    .pop_i(pop), .pop_data_o(pop_data),
    .full_o(full), .empty_o(empty), .count_o(count),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq),
    .ovf_o(ovf), .ovf_clr_i(ovf_clr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic cfg(logic [15:0] v);
    wr(16'h0000);
    wr(v);
  endtask

  task automatic do_push(logic [DW-1:0] d);
    @(negedge clk); push = 1'b1; push_data = d;
    @(negedge clk); push = 1'b0;
    last_rx = rx_irq; last_tx = tx_irq;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1; last_pop = pop_data;
    @(negedge clk); pop = 1'b0;
    last_rx = rx_irq; last_tx = tx_irq;
  endtask

  task automatic clr_ovf();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 16'h0000);
    check("R1 empty", empty, 1);
    check("R1 full", full, 1);
    check("R1 count", count, 0);
    check("R1 irq", {rx_irq, tx_irq}, 0);
    check("R1 ovf", ovf, 0);
  endtask

  task automatic t_reserved();
    wr(16'hFFFF);
    check("R2 readback", reg_rdata, 16'hF007);
    check("R4 empty", empty, 1);
    check("R4 full", full, 1);
    do_push(32'hDEAD);
    check("R4 dropped", count, 0);
    check("R6 ovf set", ovf, 1);
    @(negedge clk);
    check("R6 ovf sticky", ovf, 1);
    clr_ovf();
    check("R6 ovf clear", ovf, 0);
    wr(16'h0000);
    do_push(32'h1);
    check("R4 off dropped", count, 0);
    clr_ovf();
  endtask

  task automatic t_order();
    cfg(16'h0101);
    for (int i = 0; i < 4; i++) begin
      check("R3 not full", full, 0);
      do_push(32'hA0 + i);
    end
    check("R3 full at 4", full, 1);
    check("R3 count 4", count, 4);
    do_push(32'hFF);
    check("R6 full drop count", count, 4);
    check("R6 full drop ovf", ovf, 1);
    clr_ovf();
    for (int i = 0; i < 4; i++) begin
      do_pop();
      check("R5 order", last_pop, 32'hA0 + i);
    end
    check("R5 empty", empty, 1);
    do_pop();
    check("R5 pop empty", count, 0);
    // wrap at reduced depth
    for (int i = 0; i < 3; i++) do_push(32'hB0 + i);
    do_pop();
    check("R5 wrap a", last_pop, 32'hB0);
    do_push(32'hB3);
    do_push(32'hB4);
    for (int i = 1; i < 5; i++) begin
      do_pop();
      check("R5 wrap order", last_pop, 32'hB0 + i);
    end
  endtask

  task automatic t_depth_flush();
    cfg(16'h0301);
    for (int i = 0; i < 15; i++) do_push(i);
    check("R3 15 not full", full, 0);
    do_push(32'h55);
    check("R3 16 full", full, 1);
    check("R3 16 count", count, 16);
    wr(16'h0201);
    check("R12 depth change flush", count, 0);
    for (int i = 0; i < 3; i++) do_push(i);
    check("R12 pre", count, 3);
    wr(16'h0200);
    check("R12 disable flush", count, 0);
    check("R4 disabled full", full, 1);
  endtask

  task automatic t_rx_thr();
    logic [3:0] seen;
    cfg(16'h4203);
    for (int i = 0; i < 4; i++) begin do_push(i); seen[i] = last_rx; end
    check("R7 depth8 lvl2", seen, 4'b0100);
    cfg(16'h4103);
    for (int i = 0; i < 3; i++) begin do_push(i); seen[i] = last_rx; end
    check("R7 depth4 lvl2", seen[2:0], 3'b010);
    cfg(16'hE103);
    for (int i = 0; i < 4; i++) begin do_push(i); seen[i] = last_rx; end
    check("R7 depth4 full", seen, 4'b1000);
    cfg(16'h4201);
    seen = '0;
    for (int i = 0; i < 3; i++) begin do_push(i); seen[i] = last_rx; end
    check("R11 rxie off", seen[2:0], 3'b000);
  endtask

  task automatic t_rx_per_msg();
    logic [2:0] seen, seen_tx;
    cfg(16'h1207);
    for (int i = 0; i < 3; i++) begin
      do_push(i); seen[i] = last_rx; seen_tx[i] = last_tx;
    end
    check("R8 every push", seen, 3'b111);
    do_pop();
    check("R11 no tx in rx dir", {seen_tx, last_tx}, 4'b0000);
  endtask

  task automatic t_tx();
    logic [2:0] seen, seen_rx;
    @(negedge clk); dir_tx = 1'b1;
    cfg(16'h0207);
    for (int i = 0; i < 3; i++) begin do_push(i); seen_rx[i] = last_rx; end
    check("R11 no rx in tx dir", seen_rx, 3'b000);
    for (int i = 0; i < 3; i++) begin do_pop(); seen[i] = last_tx; end
    check("R9 empty completion", seen, 3'b100);
    do_pop();
    check("R9 pop on empty", last_tx, 0);
    cfg(16'h1205);
    do_push(1); do_push(2);
    for (int i = 0; i < 2; i++) begin do_pop(); seen[i] = last_tx; end
    check("R10 every pop", seen[1:0], 2'b11);
    cfg(16'h0201);
    do_push(1);
    do_pop();
    check("R11 txie off", last_tx, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_order();
    t_depth_flush();
    t_rx_thr();
    t_rx_per_msg();
    t_tx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule